// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Masks

This block sits beside a CPU core and decides which pending interrupt or trap the core enters next. It watches five kinds of source: an active-low non-maskable external request, an active-low maskable external request that can be sensed by level or by falling edge, an illegal-opcode trap pulse and a software-interrupt pulse from the instruction decoder, and a set of peripheral requests that can be masked one by one. When a source wins, the block raises a one-cycle take strobe together with the 16-bit vector address of that source's service routine. On the same clock edge it updates the global mask bits it owns.

The block holds the two global mask bits. The I bit blocks every maskable source as a group. The X bit blocks the non-maskable external request. Software writes both bits through a small write port. That port can clear X but can never set it. Only reset, or entry through the non-maskable request, sets X again. Among the maskable sources the order is fixed, but a promote-select value lifts any one of them to the top. Stacking the registers and sequencing the return from an interrupt stay in the CPU.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_take` is 0, `i_mask` is 1 and `x_mask` is 1.
- R2: A mask write with `mask_wr_x`=0 clears `x_mask`. A mask write with `mask_wr_x`=1 leaves `x_mask` unchanged. While `x_mask` is 1, the non-maskable request (`nmi_req_n` low) is not taken.
- R3: While `i_mask` is 1, neither the external maskable request nor any peripheral request is taken. The software-interrupt and illegal-opcode pulses are taken whatever the value of `i_mask`.
- R4: Taking any source sets `i_mask` on the same edge that raises `irq_take`. Taking the non-maskable request also sets `x_mask`. `irq_take` lasts one cycle for each entry.
- R5: Peripheral request j counts only while `per_en[j]` is 1.
- R6: The order is fixed: illegal opcode, then software interrupt, then the non-maskable request, then the maskable sources. Among the maskable sources, index 0 is the external request and index j+1 is peripheral j, and a lower index wins.
- R7: If `promote_sel` = k and k is less than NUM_PERIPH+1, maskable source k ranks above all other maskable sources. Values of NUM_PERIPH+1 or more promote nothing.
- R8: With `ext_edge_sel`=0, the external maskable request is active while `ext_req_n` is low. With `ext_edge_sel`=1, a falling edge on `ext_req_n` is latched, and the latch is cleared when that request is taken. A held-low level does not request again.
- R9: The vector addresses are 16'hFFF8 for illegal opcode, 16'hFFF6 for software interrupt, 16'hFFF4 for the non-maskable request, 16'hFFF2 for the external maskable request, and PERIPH_VEC_TOP - 2*j for peripheral j (16'hFFF0 down to 16'hFFE2 with the defaults).
- R10: An input seen before clock edge n raises `irq_take` at edge n+1. `irq_vector` is registered and changes only on an edge that raises `irq_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req_n | input | 1 | Non-maskable external request, active low, level |
| ext_req_n | input | 1 | Maskable external request, active low |
| ext_edge_sel | input | 1 | 1 = sense the external maskable request on its falling edge |
| per_req | input | NUM_PERIPH | Peripheral request levels |
| per_en | input | NUM_PERIPH | Per-peripheral enables |
| promote_sel | input | SEL_W | Index of the maskable source to promote |
| swi_stb | input | 1 | Software-interrupt pulse from the decoder |
| illop_stb | input | 1 | Illegal-opcode pulse from the decoder |
| mask_wr | input | 1 | Software write strobe for the mask bits |
| mask_wr_i | input | 1 | New I value |
| mask_wr_x | input | 1 | New X value (clear only) |
| irq_take | output | 1 | One-cycle strobe to enter an interrupt |
| irq_vector | output | 16 | Vector address of the entered source |
| i_mask | output | 1 | Global maskable-interrupt mask |
| x_mask | output | 1 | Non-maskable request mask |

## Verification
The bench builds the block with its defaults: NUM_PERIPH = 8 and PERIPH_VEC_TOP = 16'hFFF0. That gives nine maskable sources and a 4-bit promote field. Select values 9 to 15 therefore exercise the path with no promotion, and values 0, 3, 6, 7 and 8 exercise promotion of the external request and of low, middle and last peripherals. The eight peripherals give every peripheral vector down to 16'hFFE2, so the table can check the lowest-ranked source against requests at both ends of the vector.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [2:0] {
    PICK_NONE,
    PICK_ILL,
    PICK_SWI,
    PICK_NMI,
    PICK_MASKABLE
  } pick_e;

  localparam logic [15:0] VEC_ILLOP = 16'hFFF8;
  localparam logic [15:0] VEC_SWI   = 16'hFFF6;
  localparam logic [15:0] VEC_NMI   = 16'hFFF4;
  localparam logic [15:0] VEC_EXT   = 16'hFFF2;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int NUM_PERIPH = 8,
  parameter int SEL_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  nmi_req_n,
  input  logic                  ext_req_n,
  input  logic                  ext_edge_sel,
  input  logic [NUM_PERIPH-1:0] per_req,
  input  logic [NUM_PERIPH-1:0] per_en,
  input  logic [SEL_W-1:0]      promote_sel,
  input  logic                  swi_stb,
  input  logic                  illop_stb,
  input  logic                  clr_ext,
  input  logic                  clr_swi,
  input  logic                  clr_ill,
  output logic                  nmi_act,
  output logic                  ext_act,
  output logic [NUM_PERIPH-1:0] per_act,
  output logic [SEL_W-1:0]      sel_q,
  output logic                  swi_pend,
  output logic                  ill_pend
);

  logic                  ext_s;
  logic                  nmi_s;
  logic                  mode_q;
  logic                  edge_pend;
  logic [NUM_PERIPH-1:0] req_q;
  logic [NUM_PERIPH-1:0] en_q;
  logic                  fall_seen;

  // Falling edge: previous sample high, pin now low.
  assign fall_seen = ext_s & ~ext_req_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_s     <= 1'b1;
      nmi_s     <= 1'b0;
      mode_q    <= 1'b0;
      edge_pend <= 1'b0;
      req_q     <= '0;
      en_q      <= '0;
      sel_q     <= '0;
      swi_pend  <= 1'b0;
      ill_pend  <= 1'b0;
    end else begin
      ext_s    <= ext_req_n;
      nmi_s    <= ~nmi_req_n;
      mode_q   <= ext_edge_sel;
      req_q    <= per_req;
      en_q     <= per_en;
      sel_q    <= promote_sel;
      swi_pend <= (swi_pend & ~clr_swi) | swi_stb;
      ill_pend <= (ill_pend & ~clr_ill) | illop_stb;
      if (mode_q) begin
        edge_pend <= (edge_pend & ~clr_ext) | fall_seen;
      end else begin
        edge_pend <= 1'b0;
      end
    end
  end

  assign nmi_act = nmi_s;
  assign ext_act = mode_q ? edge_pend : ~ext_s;
  assign per_act = req_q & en_q;

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_i,
  input  logic wr_x,
  input  logic take,
  input  logic take_nmi,
  output logic i_bit,
  output logic x_bit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      i_bit <= 1'b1;
      x_bit <= 1'b1;
    end else if (take) begin
      i_bit <= 1'b1;
      if (take_nmi) begin
        x_bit <= 1'b1;
      end
    end else if (wr) begin
      i_bit <= wr_i;
      x_bit <= x_bit & wr_x;
    end
  end

endmodule

// File: rtl/irq_mask_pick.sv
module irq_mask_pick #(
  parameter int NUM_SRC = 9,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [SEL_W-1:0]   sel,
  output logic               found,
  output logic [SEL_W-1:0]   idx
);

  localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(NUM_SRC);

  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] first_oh;
  logic [SEL_W-1:0]   fixed_idx;
  logic               sel_ok;
  logic               prom_hit;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign first_oh[g] = req[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req[g];
  end

  always_comb begin
    fixed_idx = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (first_oh[k]) begin
        fixed_idx = SEL_W'(k);
      end
    end
  end

  assign sel_ok   = {1'b0, sel} < SEL_LIMIT;
  assign prom_hit = sel_ok && req[sel];
  assign found    = seen[NUM_SRC];
  assign idx      = prom_hit ? sel : fixed_idx;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int          NUM_PERIPH     = 8,
  parameter logic [15:0] PERIPH_VEC_TOP = 16'hFFF0,
  localparam int         NUM_MASK       = NUM_PERIPH + 1,
  localparam int         SEL_W          = $clog2(NUM_MASK)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  nmi_req_n,
  input  logic                  ext_req_n,
  input  logic                  ext_edge_sel,
  input  logic [NUM_PERIPH-1:0] per_req,
  input  logic [NUM_PERIPH-1:0] per_en,
  input  logic [SEL_W-1:0]      promote_sel,
  input  logic                  swi_stb,
  input  logic                  illop_stb,
  input  logic                  mask_wr,
  input  logic                  mask_wr_i,
  input  logic                  mask_wr_x,
  output logic                  irq_take,
  output logic [15:0]           irq_vector,
  output logic                  i_mask,
  output logic                  x_mask
);

  logic                  nmi_act;
  logic                  ext_act;
  logic [NUM_PERIPH-1:0] per_act;
  logic [SEL_W-1:0]      sel_q;
  logic                  swi_pend;
  logic                  ill_pend;
  logic                  m_found;
  logic [SEL_W-1:0]      m_idx;
  pick_e                 pick;
  logic [15:0]           next_vec;
  logic                  take_now;

  irq_req_capture #(
    .NUM_PERIPH(NUM_PERIPH),
    .SEL_W     (SEL_W)
  ) u_capture (
    .clk         (clk),
    .rst         (rst),
    .nmi_req_n   (nmi_req_n),
    .ext_req_n   (ext_req_n),
    .ext_edge_sel(ext_edge_sel),
    .per_req     (per_req),
    .per_en      (per_en),
    .promote_sel (promote_sel),
    .swi_stb     (swi_stb),
    .illop_stb   (illop_stb),
    .clr_ext     (pick == PICK_MASKABLE && m_idx == '0),
    .clr_swi     (pick == PICK_SWI),
    .clr_ill     (pick == PICK_ILL),
    .nmi_act     (nmi_act),
    .ext_act     (ext_act),
    .per_act     (per_act),
    .sel_q       (sel_q),
    .swi_pend    (swi_pend),
    .ill_pend    (ill_pend)
  );

  irq_mask_pick #(
    .NUM_SRC(NUM_MASK),
    .SEL_W  (SEL_W)
  ) u_pick (
    .req  ({per_act, ext_act}),
    .sel  (sel_q),
    .found(m_found),
    .idx  (m_idx)
  );

  // Non-maskable sources first, then the winner among the maskable ones.
  always_comb begin
    if (ill_pend) begin
      pick = PICK_ILL;
    end else if (swi_pend) begin
      pick = PICK_SWI;
    end else if (nmi_act && !x_mask) begin
      pick = PICK_NMI;
    end else if (m_found && !i_mask) begin
      pick = PICK_MASKABLE;
    end else begin
      pick = PICK_NONE;
    end
  end

  always_comb begin
    case (pick)
      PICK_ILL: next_vec = VEC_ILLOP;
      PICK_SWI: next_vec = VEC_SWI;
      PICK_NMI: next_vec = VEC_NMI;
      PICK_MASKABLE: begin
        if (m_idx == '0) begin
          next_vec = VEC_EXT;
        end else begin
          next_vec = PERIPH_VEC_TOP - {{(15-SEL_W){1'b0}}, m_idx - SEL_W'(1), 1'b0};
        end
      end
      default: next_vec = irq_vector;
    endcase
  end

  assign take_now = (pick != PICK_NONE);

  irq_mask_regs u_masks (
    .clk     (clk),
    .rst     (rst),
    .wr      (mask_wr),
    .wr_i    (mask_wr_i),
    .wr_x    (mask_wr_x),
    .take    (take_now),
    .take_nmi(pick == PICK_NMI),
    .i_bit   (i_mask),
    .x_bit   (x_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take   <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_take <= take_now;
      if (take_now) begin
        irq_vector <= next_vec;
      end
    end
  end

endmodule

// File: rtl/irq_arbiter_checker.sv
module irq_arbiter_checker (
  input logic        clk,
  input logic        rst,
  input logic        irq_take,
  input logic [15:0] irq_vector,
  input logic        i_mask,
  input logic        x_mask
);

  AST_RESET_MASKS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (i_mask && x_mask && !irq_take)); // R1

  AST_X_SET_ONLY_BY_NMI: assert property (@(posedge clk) disable iff (rst)
    $rose(x_mask) |-> (irq_take && irq_vector == 16'hFFF4)); // R2

  AST_NMI_NEEDS_X_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_vector == 16'hFFF4) |-> !$past(x_mask)); // R2

  AST_MASKABLE_NEEDS_I_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_vector <= 16'hFFF2) |-> !$past(i_mask)); // R3

  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> i_mask); // R4

  AST_VECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
    !irq_take |-> $stable(irq_vector)); // R10

endmodule

bind irq_arbiter irq_arbiter_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .irq_take  (irq_take),
  .irq_vector(irq_vector),
  .i_mask    (i_mask),
  .x_mask    (x_mask)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_req_n = 1'b1;
  logic        ext_req_n = 1'b1;
  logic        ext_edge_sel = 1'b0;
  logic [7:0]  per_req = '0;
  logic [7:0]  per_en = '0;
  logic [3:0]  promote_sel = 4'd15;
  logic        swi_stb = 1'b0;
  logic        illop_stb = 1'b0;
  logic        mask_wr = 1'b0;
  logic        mask_wr_i = 1'b1;
  logic        mask_wr_x = 1'b1;
  logic        irq_take;
  logic [15:0] irq_vector;
  logic        i_mask;
  logic        x_mask;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk         (clk),
    .rst         (rst),
    .nmi_req_n   (nmi_req_n),
    .ext_req_n   (ext_req_n),
    .ext_edge_sel(ext_edge_sel),
    .per_req     (per_req),
    .per_en      (per_en),
    .promote_sel (promote_sel),
    .swi_stb     (swi_stb),
    .illop_stb   (illop_stb),
    .mask_wr     (mask_wr),
    .mask_wr_i   (mask_wr_i),
    .mask_wr_x   (mask_wr_x),
    .irq_take    (irq_take),
    .irq_vector  (irq_vector),
    .i_mask      (i_mask),
    .x_mask      (x_mask)
  );

  // Each row: per_req, per_en, ext low, promote_sel, expected take, expected vector
  localparam logic [37:0] TBL [12] = '{
    {8'h01, 8'hFF, 1'b0, 4'd15, 1'b1, 16'hFFF0},
    {8'h80, 8'hFF, 1'b0, 4'd15, 1'b1, 16'hFFE2},
    {8'h90, 8'hFF, 1'b0, 4'd15, 1'b1, 16'hFFE8},
    {8'h90, 8'hFF, 1'b0, 4'd8,  1'b1, 16'hFFE2},
    {8'h06, 8'hFF, 1'b1, 4'd15, 1'b1, 16'hFFF2},
    {8'h06, 8'hFF, 1'b1, 4'd3,  1'b1, 16'hFFEC},
    {8'h06, 8'hFB, 1'b0, 4'd15, 1'b1, 16'hFFEE},
    {8'h00, 8'hFF, 1'b0, 4'd5,  1'b0, 16'h0000},
    {8'hFF, 8'h00, 1'b0, 4'd15, 1'b0, 16'h0000},
    {8'h41, 8'hFF, 1'b0, 4'd7,  1'b1, 16'hFFE4},
    {8'h41, 8'hFF, 1'b1, 4'd0,  1'b1, 16'hFFF2},
    {8'h20, 8'hFF, 1'b0, 4'd6,  1'b1, 16'hFFE6}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse the mask write port; call at a negedge, returns at the next one.
  task automatic mask_write(input logic wi, input logic wx);
    mask_wr = 1'b1; mask_wr_i = wi; mask_wr_x = wx;
    tick(1);
    mask_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 take after reset", 32'(irq_take), 32'd0);
    chk("R1 i_mask after reset", 32'(i_mask), 32'd1);
    chk("R1 x_mask after reset", 32'(x_mask), 32'd1);

    // R3: I set blocks the maskable sources
    ext_req_n = 1'b0; per_req = 8'h01; per_en = 8'h01;
    tick(1);
    chk("R3 no take at n+1", 32'(irq_take), 32'd0);
    tick(2);
    chk("R3 maskable blocked by I", 32'(irq_take), 32'd0);
    ext_req_n = 1'b1; per_req = '0; per_en = '0;
    tick(1);

    // Table: R5 R6 R7 R8 R9 R10 with I cleared before each row
    for (int e = 0; e < 12; e++) begin
      logic [37:0] row;
      row = TBL[e];
      per_req = '0; per_en = '0; ext_req_n = 1'b1;
      tick(1);
      per_req = row[37:30]; per_en = row[29:22];
      ext_req_n = ~row[21]; promote_sel = row[20:17];
      mask_write(1'b0, 1'b1);
      tick(1);
      chk($sformatf("R6/R7/R5 row %0d take", e), 32'(irq_take), 32'(row[16]));
      if (row[16]) begin
        chk($sformatf("R9/R7 row %0d vector", e), 32'(irq_vector), 32'(row[15:0]));
      end
      tick(1);
      chk($sformatf("R4 row %0d one-shot", e), 32'(irq_take), 32'd0);
      if (row[16]) begin
        chk($sformatf("R4 row %0d I set", e), 32'(i_mask), 32'd1);
      end
    end
    per_req = '0; per_en = '0; ext_req_n = 1'b1; promote_sel = 4'd15;
    tick(1);
    mask_write(1'b1, 1'b1);
    tick(1);

    // R2: X can be cleared but not set by software
    mask_write(1'b1, 1'b0);
    chk("R2 X cleared", 32'(x_mask), 32'd0);
    mask_write(1'b1, 1'b1);
    chk("R2 X not set by write", 32'(x_mask), 32'd0);

    // Non-maskable entry
    nmi_req_n = 1'b0;
    tick(1);
    chk("R10 NMI not yet at n+1", 32'(irq_take), 32'd0);
    tick(1);
    chk("R9 NMI vector", 32'(irq_vector), 32'hFFF4);
    chk("R4 NMI take", 32'(irq_take), 32'd1);
    chk("R4 NMI sets X", 32'(x_mask), 32'd1);
    tick(1);
    chk("R2 NMI held low not retaken", 32'(irq_take), 32'd0);
    nmi_req_n = 1'b1;
    tick(2);

    // R6: illegal opcode, software interrupt and NMI together, I still set (R3)
    nmi_req_n = 1'b0; swi_stb = 1'b1; illop_stb = 1'b1;
    mask_wr = 1'b1; mask_wr_i = 1'b1; mask_wr_x = 1'b0;
    tick(1);
    swi_stb = 1'b0; illop_stb = 1'b0; mask_wr = 1'b0;
    tick(1);
    chk("R6 illegal opcode first", 32'(irq_vector), 32'hFFF8);
    chk("R3 trap taken with I set", 32'(irq_take), 32'd1);
    tick(1);
    chk("R6 software interrupt second", 32'(irq_vector), 32'hFFF6);
    chk("R3 SWI taken with I set", 32'(irq_take), 32'd1);
    tick(1);
    chk("R6 NMI third", 32'(irq_vector), 32'hFFF4);
    tick(1);
    chk("R6 nothing after", 32'(irq_take), 32'd0);
    nmi_req_n = 1'b1;
    tick(2);

    // R8: edge mode
    ext_edge_sel = 1'b1;
    tick(2);
    mask_write(1'b0, 1'b1);
    ext_req_n = 1'b0;
    tick(2);
    chk("R8 edge take", 32'(irq_take), 32'd1);
    chk("R8 edge vector", 32'(irq_vector), 32'hFFF2);
    tick(1);
    mask_write(1'b0, 1'b1);
    tick(3);
    chk("R8 held low not retaken in edge mode", 32'(irq_take), 32'd0);
    ext_edge_sel = 1'b0;
    tick(2);
    chk("R8 level mode takes held low", 32'(irq_take), 32'd1);
    chk("R8 level vector", 32'(irq_vector), 32'hFFF2);
    ext_req_n = 1'b1;
    tick(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule